// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a free-running watchdog that advances on a tick from the low-speed clock. Software must keep it quiet by writing a two-byte key sequence to its clear input. If it does not, the first overflow raises a non-maskable interrupt. If a second overflow arrives while that interrupt is still pending and no clear has come in between, the block requests a system reset. A two-bit select field picks one of four overflow periods. With the default base setting and a 32.768 kHz tick, these are 4096, 16384, 65536 and 262144 ticks, or 125 ms, 500 ms, 2 s and 8 s.

The escalation is a three-state machine. `ESC_RUN` is the quiet state: the count runs and no output is raised. `ESC_NMI` means the interrupt is pending. `ESC_RESET` is the terminal state, in which the reset request is held. The transitions are:

- RUN→NMI on an overflow.
- NMI→RUN on a clear.
- NMI→RESET on an overflow.
- RESET→RESET, always, until the block's own reset.

The key checker is a two-state machine. `KEY_IDLE` waits for the first key. `KEY_ARMED` has seen the first key and waits for the second. The transitions are:

- IDLE→ARMED on a write of the first key.
- ARMED→IDLE, with a clear, on a write of the second key.
- ARMED→ARMED on a repeated first key.
- Any other write returns the checker to IDLE.

Cycles without a write leave the key state unchanged.

Top module: `wdog_escalator`

## Requirements
- R1: After reset, `nmi_o` and `rst_req_o` are both 0, and the tick count is 0.
- R2: With select value s, the period is P = 2^(BASE_LOG2 + 2*s) ticks. `nmi_o` rises on the clock edge that takes the P-th tick after a restart, and not before.
- R3: While the NMI is pending, the count restarts from 0 at the overflow and keeps running.
- R4: A second overflow in `ESC_NMI`, with no clear, raises `rst_req_o` on the edge of the P-th tick after the first overflow. `rst_req_o` never rises unless `nmi_o` was already high.
- R5: Clock cycles with `tick`=0 do not advance the count.
- R6: A clear is a write of KEY_FIRST (default 8'h3C) on `wr_data`, followed by a write of KEY_SECOND (default 8'hC3) as the next write. Idle cycles may separate the two writes. A clear restarts the count from 0.
- R7: A clear in `ESC_NMI` returns the block to `ESC_RUN`, and `nmi_o` falls on the same edge.
- R8: The count is not cleared by any of the following: a write of any other value, KEY_SECOND without an immediately preceding KEY_FIRST, or a reversed order.
- R9: Once `rst_req_o` is 1, it stays 1 and `nmi_o` stays 1 until `rst_n` is asserted. Clears are then ignored.
- R10: When a clear and an overflowing tick fall in the same cycle, the clear wins and no escalation happens.
- R11: If the select field is changed to a period whose last count is at or below the current count, the next tick overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle pulse per low-speed clock period |
| wr_en | input | 1 | Write strobe for the clear register |
| wr_data | input | KEY_W | Byte written to the clear register |
| period_sel | input | 2 | Overflow period select: 0 shortest … 3 longest |
| nmi_o | output | 1 | Non-maskable interrupt request (level) |
| rst_req_o | output | 1 | Reset request (sticky level) |

## Verification
The bench builds the block with BASE_LOG2 = 2, so the four periods shrink to 4, 16, 64 and 256 ticks. At that size, every select value can be driven through both escalation thresholds, checking the cycle one tick before each threshold and the cycle on it. The short 4-tick period places a clear, a wrong key sequence or a period change one tick away from an overflow. That exposes the same-cycle clear priority and the handling of a count left beyond a shrunk period. Each expected edge is computed as 2^(2+2s) ticks from the last restart.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ESC_RUN   = 2'd0,
        ESC_NMI   = 2'd1,
        ESC_RESET = 2'd2
    } esc_state_t;

    typedef enum logic {
        KEY_IDLE  = 1'b0,
        KEY_ARMED = 1'b1
    } key_state_t;

    localparam int SEL_W     = 2;
    localparam int NUM_SEL   = 1 << SEL_W;
    localparam int SEL_SHIFT = 2;   // each select step multiplies the period by 4

endpackage

// File: rtl/wdog_key_check.sv
module wdog_key_check
    import wdog_pkg::*;
#(
    parameter int              KEY_W      = 8,
    parameter logic [KEY_W-1:0] KEY_FIRST  = 8'h3C,
    parameter logic [KEY_W-1:0] KEY_SECOND = 8'hC3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_data,
    output logic             clr_o
);

    key_state_t key_q, key_d;
    logic       hit_first, hit_second;

    assign hit_first  = wr_en && (wr_data == KEY_FIRST);
    assign hit_second = wr_en && (wr_data == KEY_SECOND);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) key_q <= KEY_IDLE;
        else        key_q <= key_d;
    end

    always_comb begin
        key_d = key_q;
        clr_o = 1'b0;
        unique case (key_q)
            KEY_IDLE: begin
                if (hit_first) key_d = KEY_ARMED;
            end
            KEY_ARMED: begin
                if (hit_second) begin
                    key_d = KEY_IDLE;
                    clr_o = 1'b1;
                end else if (hit_first) begin
                    key_d = KEY_ARMED;
                end else if (wr_en) begin
                    key_d = KEY_IDLE;
                end
            end
            default: key_d = KEY_IDLE;
        endcase
    end

    AST_BAD_WRITE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit_first && !hit_second) |=> (key_q == KEY_IDLE)); // R8

    AST_CLEAR_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        clr_o |-> $past(hit_first) || $past(key_q == KEY_ARMED)); // R6

endmodule

// File: rtl/wdog_tick_counter.sv
module wdog_tick_counter
    import wdog_pkg::*;
#(
    parameter int BASE_LOG2 = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             clr,
    input  logic [SEL_W-1:0] period_sel,
    output logic             ovf_o
);

    localparam int CNT_W = BASE_LOG2 + SEL_SHIFT * (NUM_SEL - 1);

    logic [CNT_W-1:0] last_tbl [NUM_SEL];
    logic [CNT_W-1:0] last_cnt;
    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    genvar g;
    generate
        for (g = 0; g < NUM_SEL; g++) begin : g_period
            assign last_tbl[g] = (CNT_W'(1) << (BASE_LOG2 + SEL_SHIFT * g)) - CNT_W'(1);
        end
    endgenerate

    assign last_cnt = last_tbl[period_sel];
    assign at_end   = (cnt_q >= last_cnt);
    assign ovf_o    = tick && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (clr)    cnt_q <= '0;
        else if (tick)   cnt_q <= at_end ? '0 : cnt_q + CNT_W'(1);
    end

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0)); // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(cnt_q)); // R5

    AST_WRAP_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (cnt_q == '0)); // R3

endmodule

// File: rtl/wdog_escalator.sv
module wdog_escalator
    import wdog_pkg::*;
#(
    parameter int               BASE_LOG2  = 12,
    parameter int               KEY_W      = 8,
    parameter logic [KEY_W-1:0] KEY_FIRST  = 8'h3C,
    parameter logic [KEY_W-1:0] KEY_SECOND = 8'hC3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [KEY_W-1:0] wr_data,
    input  logic [1:0]       period_sel,
    output logic             nmi_o,
    output logic             rst_req_o
);

    logic       clr;
    logic       ovf;
    esc_state_t esc_q, esc_d;

    wdog_key_check #(
        .KEY_W      (KEY_W),
        .KEY_FIRST  (KEY_FIRST),
        .KEY_SECOND (KEY_SECOND)
    ) key_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .clr_o   (clr)
    );

    wdog_tick_counter #(
        .BASE_LOG2 (BASE_LOG2)
    ) cnt_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .clr        (clr),
        .period_sel (period_sel),
        .ovf_o      (ovf)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) esc_q <= ESC_RUN;
        else        esc_q <= esc_d;
    end

    // next state: clear outranks overflow; reset state is terminal
    always_comb begin
        esc_d = esc_q;
        unique case (esc_q)
            ESC_RUN: begin
                if (!clr && ovf) esc_d = ESC_NMI;
            end
            ESC_NMI: begin
                if (clr)      esc_d = ESC_RUN;
                else if (ovf) esc_d = ESC_RESET;
            end
            ESC_RESET: esc_d = ESC_RESET;
            default:   esc_d = ESC_RUN;
        endcase
    end

    // outputs
    always_comb begin
        nmi_o     = 1'b0;
        rst_req_o = 1'b0;
        unique case (esc_q)
            ESC_RUN:   ;
            ESC_NMI:   nmi_o = 1'b1;
            ESC_RESET: begin
                nmi_o     = 1'b1;
                rst_req_o = 1'b1;
            end
            default:   ;
        endcase
    end

    AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_o |=> (rst_req_o && nmi_o)); // R9

    AST_NMI_BEFORE_RST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> $past(nmi_o)); // R4

    AST_CLEAR_DROPS_NMI: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !rst_req_o) |=> !nmi_o); // R7

    AST_CLEAR_BEATS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && ovf && !rst_req_o) |=> !rst_req_o); // R10

endmodule

// File: tb/wdog_escalator_tb_top.sv
module wdog_escalator_tb_top;

    localparam int   BASE = 2;
    localparam logic [7:0] KA = 8'h3C;
    localparam logic [7:0] KB = 8'hC3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [1:0] period_sel = '0;
    logic       nmi_o, rst_req_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    wdog_escalator #(
        .BASE_LOG2  (BASE),
        .KEY_W      (8),
        .KEY_FIRST  (KA),
        .KEY_SECOND (KB)
    ) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .period_sel (period_sel),
        .nmi_o      (nmi_o),
        .rst_req_o  (rst_req_o)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // one clock cycle with the given inputs; outputs are sampled 1 ns after the edge
    task automatic cyc(input logic t, input logic w, input logic [7:0] d);
        tick = t; wr_en = w; wr_data = d;
        @(posedge clk); #1;
        tick = 1'b0; wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 8'h00);
    endtask

    task automatic do_reset(input logic [1:0] sel);
        rst_n = 1'b0;
        period_sel = sel;
        @(posedge clk); @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
    endtask

    function automatic int per(input int s);
        return 1 << (BASE + 2 * s);
    endfunction

    initial begin
        int p;
        do_reset(2'd0);
        check("R1 nmi after reset", nmi_o, 1'b0);
        check("R1 rst_req after reset", rst_req_o, 1'b0);

        // R2 R3 R4: full sweep over the four periods
        for (int s = 0; s < 4; s++) begin
            p = per(s);
            do_reset(2'(s));
            ticks(p - 1);
            check("R2 nmi low one tick early", nmi_o, 1'b0);
            ticks(1);
            check("R2 nmi at period", nmi_o, 1'b1);
            check("R3 no reset at first overflow", rst_req_o, 1'b0);
            ticks(p - 1);
            check("R4 rst_req low one tick early", rst_req_o, 1'b0);
            check("R3 nmi held while counting", nmi_o, 1'b1);
            ticks(1);
            check("R4 rst_req at second overflow", rst_req_o, 1'b1);
        end

        // R5: idle cycles do not advance
        p = per(0);
        do_reset(2'd0);
        ticks(p - 1);
        for (int i = 0; i < 10; i++) cyc(1'b0, 1'b0, 8'h00);
        check("R5 idle cycles no overflow", nmi_o, 1'b0);
        ticks(1);
        check("R5 overflow after idle", nmi_o, 1'b1);

        // R6: clear restarts the count, idle gap between keys allowed
        do_reset(2'd0);
        ticks(p - 1);
        cyc(1'b0, 1'b1, KA);
        cyc(1'b0, 1'b0, 8'h00);
        cyc(1'b0, 1'b1, KB);
        ticks(p - 1);
        check("R6 count restarted by clear", nmi_o, 1'b0);
        ticks(1);
        check("R6 overflow one period after clear", nmi_o, 1'b1);

        // R7: clear removes pending NMI
        cyc(1'b0, 1'b1, KA);
        cyc(1'b0, 1'b1, KB);
        check("R7 nmi dropped by clear", nmi_o, 1'b0);
        ticks(p);
        check("R7 new nmi, not reset", nmi_o, 1'b1);
        check("R7 no reset after clear", rst_req_o, 1'b0);

        // R8: bad sequences
        do_reset(2'd0);
        ticks(p - 1);
        cyc(1'b0, 1'b1, KA);
        cyc(1'b0, 1'b1, 8'h00);
        cyc(1'b0, 1'b1, KB);
        ticks(1);
        check("R8 interrupted sequence does not clear", nmi_o, 1'b1);
        do_reset(2'd0);
        ticks(p - 1);
        cyc(1'b0, 1'b1, KB);
        cyc(1'b0, 1'b1, KA);
        ticks(1);
        check("R8 reversed order does not clear", nmi_o, 1'b1);

        // R9: reset request sticky, clears ignored
        do_reset(2'd0);
        ticks(2 * p);
        cyc(1'b0, 1'b1, KA);
        cyc(1'b0, 1'b1, KB);
        check("R9 rst_req stays after clear", rst_req_o, 1'b1);
        check("R9 nmi stays after clear", nmi_o, 1'b1);
        ticks(p);
        check("R9 rst_req stays over time", rst_req_o, 1'b1);

        // R10: clear and overflow in the same cycle
        do_reset(2'd0);
        ticks(p - 1);
        cyc(1'b0, 1'b1, KA);
        cyc(1'b1, 1'b1, KB);
        check("R10 clear wins over overflow", nmi_o, 1'b0);
        ticks(p - 1);
        check("R10 count restarted", nmi_o, 1'b0);
        ticks(1);
        check("R10 overflow a full period later", nmi_o, 1'b1);

        // R11: shrinking the period past the current count
        do_reset(2'd3);
        ticks(10);
        check("R11 no overflow at long period", nmi_o, 1'b0);
        period_sel = 2'd0;
        ticks(1);
        check("R11 overflow after shrink", nmi_o, 1'b1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog timeout actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule